// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Controller

This block drives a three-wire serial EEPROM organised as 16-bit words. The host issues a request with an operation, an 8-bit word address and, for writes, a data word. The block then generates every select, clock and data-out transition itself and reads data-in where the protocol needs it. When the operation is finished, it reports a one-cycle completion pulse, an error flag and the read word.

Each request runs as a fixed series of command frames with the device deselected between them. A read sends one read frame, clocks in sixteen data bits and deselects. A write is always four commands in this order: write-enable, erase, program, write-disable. After the erase and after the program the block deselects, selects the device again and polls its ready line. A protect request sends only the write-disable command. Every phase of the serial waveform has the same length, which is a parameter. Each ready poll is bounded by a parameterised limit, and a poll that reaches the limit stops the request with an error.

Top module: `seep_ctrl`

## Requirements
- R1: While reset is high and afterwards until the first accepted request, `ack`, `busy`, `done`, `err`, `ee_cs`, `ee_sk` and `ee_do` are all low.
- R2: A request is accepted on a rising edge where `req` is high and `busy` is low. In the next cycle `ack` is high for that one cycle only, `busy` goes high, and the first serial phase begins. Op encoding: 2'b00 read, 2'b01 write, 2'b10 and 2'b11 protect.
- R3: Every serial phase lasts exactly PHASE_CYC clocks. A transmitted bit takes three phases with `ee_cs` high and `ee_do` holding the bit: `ee_sk` low, then high, then low. Frames are sent MSB first.
- R4: A read sends start bit 1, opcode 2'b10 and the 8-bit address. It then receives 16 bits, MSB first, at two phases per bit: `ee_sk` high then low, with `ee_cs` high and `ee_do` low. Each bit is the value of `ee_di` at the end of its clock-high phase. One deselect phase follows, and the word appears on `rdata` with `done`.
- R5: A write sends the following, in order, with one deselect phase (`ee_cs`, `ee_sk`, `ee_do` low) after each frame: the enable frame 1,00,11111111; the erase frame 1,11,address; a ready poll; the program frame 1,01,address,data (27 bits); a second ready poll; and the disable frame 1,00,00000000.
- R6: Each ready-poll phase has `ee_cs` high and `ee_sk` and `ee_do` low. `ee_di` is sampled at the end of every poll phase. A sampled 1 ends the poll, and one deselect phase follows.
- R7: If POLL_LIMIT consecutive poll phases all sample 0, the block deselects for one phase and ends the request without sending anything further. `done` then comes with `err` high.
- R8: A protect request sends only the disable frame 1,00,00000000 and then one deselect phase.
- R9: `done` is a one-cycle pulse in the cycle after the final deselect phase. `busy` is low in that same cycle. `err` changes only in that cycle, and it is low for a request that completed normally.
- R10: A request presented while `busy` is high is ignored. It gives no `ack`, and the serial waveform and results of the running request are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | Operation: 00 read, 01 write, 1x protect |
| addr | input | 8 | Word address |
| wdata | input | 16 | Word to write |
| ack | output | 1 | One-cycle acceptance pulse |
| busy | output | 1 | High while a request is running |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready-poll timeout flag of the last request |
| rdata | output | 16 | Word from the last read |
| ee_cs | output | 1 | Device select |
| ee_sk | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data / ready from the device |

## Verification
`ack`, `busy` and the first serial phase are all due in the cycle after the accepting edge. Each later phase starts exactly PHASE_CYC clocks after the one before it, and `done` is due in the single cycle after the last deselect phase ends. The bench builds the expected phase list for each request from the frame layouts above. It drives `ee_di` per phase, holding it for the whole phase, so that the block samples it at the phase's last edge. It then steps through the list one clock at a time and compares on the falling edge, so that every pin, `busy`, `ack` and `done` is checked in exactly the cycle it is due. `rdata` and `err` are checked in the `done` cycle.

// File: rtl/seep_pkg.sv
package seep_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int OPC_W  = 2;
    localparam int HDR_W  = 1 + OPC_W + ADDR_W;
    localparam int FRM_W  = HDR_W + DATA_W;
    localparam int CNT_W  = $clog2(FRM_W + 1);

    typedef enum logic [2:0] {CMD_READ, CMD_WREN, CMD_ERASE, CMD_PROG, CMD_WRDIS} cmd_e;
    typedef enum logic [1:0] {SEG_SHIFT, SEG_RECV, SEG_DESEL, SEG_POLL} seg_e;
    typedef enum logic [1:0] {ENG_NONE, ENG_OUT, ENG_IN} eng_e;

    typedef struct packed {
        logic [FRM_W-1:0] bits;
        logic [CNT_W-1:0] len;
    } frame_t;

    function automatic frame_t make_frame(cmd_e c, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        frame_t f;
        f.len = CNT_W'(HDR_W);
        case (c)
            CMD_READ:  f.bits = {1'b1, 2'b10, a, {DATA_W{1'b0}}};
            CMD_WREN:  f.bits = {1'b1, 2'b00, {ADDR_W{1'b1}}, {DATA_W{1'b0}}};
            CMD_ERASE: f.bits = {1'b1, 2'b11, a, {DATA_W{1'b0}}};
            CMD_PROG: begin
                f.bits = {1'b1, 2'b01, a, d};
                f.len  = CNT_W'(FRM_W);
            end
            default:   f.bits = {1'b1, 2'b00, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
        endcase
        return f;
    endfunction

    function automatic cmd_e first_cmd(logic [1:0] op);
        case (op)
            2'b00:   return CMD_READ;
            2'b01:   return CMD_WREN;
            default: return CMD_WRDIS;
        endcase
    endfunction

    function automatic cmd_e cmd_after(cmd_e c);
        case (c)
            CMD_WREN:  return CMD_ERASE;
            CMD_ERASE: return CMD_PROG;
            default:   return CMD_WRDIS;
        endcase
    endfunction

    function automatic logic cmd_last(cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRDIS);
    endfunction

    function automatic logic cmd_polls(cmd_e c);
        return (c == CMD_ERASE) || (c == CMD_PROG);
    endfunction
endpackage

// File: rtl/seep_phase_timer.sv
module seep_phase_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;

    logic [PW-1:0] cnt_q;

    assign tick = run && (cnt_q == PW'(PHASE_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run)
            cnt_q <= tick ? '0 : cnt_q + PW'(1);
    end
endmodule

// File: rtl/seep_bit_engine.sv
module seep_bit_engine
    import seep_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  eng_e                load_mode,
    input  frame_t              load_frame,
    input  logic                step,
    input  logic                di,
    output logic                sk,
    output logic                dout,
    output logic                fin,
    output logic [DATA_W-1:0]   rx
);
    eng_e              mode_q;
    logic [FRM_W-1:0]  sr_q;
    logic [CNT_W-1:0]  left_q;
    logic [1:0]        sub_q;
    logic              sk_q, do_q;
    logic [DATA_W-1:0] rx_q;

    always_comb begin
        case (mode_q)
            ENG_OUT: fin = (left_q == CNT_W'(1)) && (sub_q == 2'd2);
            ENG_IN:  fin = (left_q == CNT_W'(1)) && (sub_q == 2'd1);
            default: fin = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ENG_NONE;
            sr_q   <= '0;
            left_q <= '0;
            sub_q  <= '0;
            sk_q   <= 1'b0;
            do_q   <= 1'b0;
            rx_q   <= '0;
        end else if (load) begin
            mode_q <= load_mode;
            sr_q   <= load_frame.bits;
            left_q <= load_frame.len;
            sub_q  <= '0;
            sk_q   <= (load_mode == ENG_IN);
            do_q   <= (load_mode == ENG_OUT) && load_frame.bits[FRM_W-1];
            if (load_mode == ENG_IN)
                rx_q <= '0;
        end else if (step) begin
            case (mode_q)
                ENG_OUT: begin
                    case (sub_q)
                        2'd0: begin sk_q <= 1'b1; sub_q <= 2'd1; end
                        2'd1: begin sk_q <= 1'b0; sub_q <= 2'd2; end
                        default: begin
                            sub_q  <= 2'd0;
                            left_q <= left_q - CNT_W'(1);
                            sr_q   <= sr_q << 1;
                            do_q   <= sr_q[FRM_W-2];
                        end
                    endcase
                end
                ENG_IN: begin
                    if (sub_q == 2'd0) begin
                        rx_q  <= {rx_q[DATA_W-2:0], di};
                        sk_q  <= 1'b0;
                        sub_q <= 2'd1;
                    end else begin
                        sub_q  <= 2'd0;
                        left_q <= left_q - CNT_W'(1);
                        sk_q   <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sk   = sk_q;
    assign dout = do_q;
    assign rx   = rx_q;
endmodule

// File: rtl/seep_seq.sv
module seep_seq
    import seep_pkg::*;
#(
    parameter int POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              eng_fin,
    input  logic              di,
    input  logic [DATA_W-1:0] eng_rx,
    output logic              ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              cs,
    output logic              eng_load,
    output eng_e              eng_mode,
    output frame_t            eng_frame,
    output logic              tmr_clear
);
    localparam int PCW = $clog2(POLL_LIMIT + 1);

    cmd_e              cmd_q, nxt_cmd;
    seg_e              seg_q, nxt_seg;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [PCW-1:0]    pcnt_q;
    logic              polled_q, fail_q;
    logic              ack_q, busy_q, done_q, err_q, cs_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept, adv, finish, ready, timeout;

    assign accept = req && !busy_q;
    assign adv    = busy_q && tick && eng_fin;

    always_comb begin
        nxt_seg = seg_q;
        nxt_cmd = cmd_q;
        finish  = 1'b0;
        ready   = 1'b0;
        timeout = 1'b0;
        if (accept) begin
            nxt_seg = SEG_SHIFT;
            nxt_cmd = first_cmd(op);
        end else if (adv) begin
            case (seg_q)
                SEG_SHIFT: nxt_seg = (cmd_q == CMD_READ) ? SEG_RECV : SEG_DESEL;
                SEG_RECV:  nxt_seg = SEG_DESEL;
                SEG_POLL: begin
                    if (di) begin
                        ready   = 1'b1;
                        nxt_seg = SEG_DESEL;
                    end else if (pcnt_q == PCW'(POLL_LIMIT - 1)) begin
                        timeout = 1'b1;
                        nxt_seg = SEG_DESEL;
                    end
                end
                default: begin
                    if (fail_q || cmd_last(cmd_q))
                        finish = 1'b1;
                    else if (cmd_polls(cmd_q) && !polled_q)
                        nxt_seg = SEG_POLL;
                    else begin
                        nxt_seg = SEG_SHIFT;
                        nxt_cmd = cmd_after(cmd_q);
                    end
                end
            endcase
        end
    end

    always_comb begin
        eng_load  = accept || adv;
        tmr_clear = accept;
        eng_frame = make_frame(nxt_cmd, accept ? addr : addr_q, accept ? wdata : wdata_q);
        if (finish)
            eng_mode = ENG_NONE;
        else if (nxt_seg == SEG_SHIFT)
            eng_mode = ENG_OUT;
        else if (nxt_seg == SEG_RECV) begin
            eng_mode       = ENG_IN;
            eng_frame.bits = '0;
            eng_frame.len  = CNT_W'(DATA_W);
        end else
            eng_mode = ENG_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= CMD_READ;
            seg_q    <= SEG_DESEL;
            addr_q   <= '0;
            wdata_q  <= '0;
            pcnt_q   <= '0;
            polled_q <= 1'b0;
            fail_q   <= 1'b0;
            ack_q    <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            cs_q     <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ack_q  <= accept;
            done_q <= 1'b0;
            if (accept) begin
                busy_q   <= 1'b1;
                cmd_q    <= nxt_cmd;
                seg_q    <= SEG_SHIFT;
                cs_q     <= 1'b1;
                addr_q   <= addr;
                wdata_q  <= wdata;
                pcnt_q   <= '0;
                polled_q <= 1'b0;
                fail_q   <= 1'b0;
            end else if (adv) begin
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    cs_q   <= 1'b0;
                    err_q  <= fail_q;
                    if (cmd_q == CMD_READ)
                        rdata_q <= eng_rx;
                end else begin
                    seg_q  <= nxt_seg;
                    cmd_q  <= nxt_cmd;
                    cs_q   <= (nxt_seg != SEG_DESEL);
                    pcnt_q <= (seg_q == SEG_POLL) ? pcnt_q + PCW'(1) : '0;
                    if (ready)
                        polled_q <= 1'b1;
                    if (timeout)
                        fail_q <= 1'b1;
                    if (seg_q == SEG_DESEL && nxt_seg == SEG_SHIFT)
                        polled_q <= 1'b0;
                end
            end
        end
    end

    assign ack   = ack_q;
    assign busy  = busy_q;
    assign done  = done_q;
    assign err   = err_q;
    assign rdata = rdata_q;
    assign cs    = cs_q;
endmodule

// File: rtl/seep_ctrl.sv
module seep_ctrl
    import seep_pkg::*;
#(
    parameter int PHASE_CYC  = 4,
    parameter int POLL_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_do,
    input  logic              ee_di
);
    logic              tick, tmr_clear, eng_load, eng_fin;
    eng_e              eng_mode;
    frame_t            eng_frame;
    logic [DATA_W-1:0] eng_rx;

    seep_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .run   (busy),
        .tick  (tick)
    );

    seep_bit_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .load       (eng_load),
        .load_mode  (eng_mode),
        .load_frame (eng_frame),
        .step       (tick),
        .di         (ee_di),
        .sk         (ee_sk),
        .dout       (ee_do),
        .fin        (eng_fin),
        .rx         (eng_rx)
    );

    seep_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .op        (op),
        .addr      (addr),
        .wdata     (wdata),
        .tick      (tick),
        .eng_fin   (eng_fin),
        .di        (ee_di),
        .eng_rx    (eng_rx),
        .ack       (ack),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .cs        (ee_cs),
        .eng_load  (eng_load),
        .eng_mode  (eng_mode),
        .eng_frame (eng_frame),
        .tmr_clear (tmr_clear)
    );
endmodule

// File: rtl/seep_ctrl_chk.sv
module seep_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ack,
    input logic busy,
    input logic done,
    input logic err,
    input logic ee_cs,
    input logic ee_sk,
    input logic ee_do
);
    AST_BUSY_STARTS_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ack); // R2
    AST_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ack |-> busy); // R2
    AST_SK_UNDER_SELECT: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs); // R3
    AST_DATA_HELD_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(ee_sk) |-> $stable(ee_do)); // R3
    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!ee_cs && !ee_sk && !ee_do)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done); // R7
endmodule

bind seep_ctrl seep_ctrl_chk u_seep_chk (
    .clk   (clk),
    .rst   (rst),
    .ack   (ack),
    .busy  (busy),
    .done  (done),
    .err   (err),
    .ee_cs (ee_cs),
    .ee_sk (ee_sk),
    .ee_do (ee_do)
);

// File: tb/test_seep_ctrl.sv
module test_seep_ctrl;
    localparam int PH = 3;
    localparam int PL = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        ee_di = 1'b0;
    logic        ack, busy, done, err, ee_cs, ee_sk, ee_do;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;
    logic [3:0] ph_q[$];

    always #4 clk = ~clk;

    seep_ctrl #(.PHASE_CYC(PH), .POLL_LIMIT(PL)) i_seep_ctrl (
        .clk(clk), .rst(rst), .req(req), .op(op), .addr(addr), .wdata(wdata),
        .ack(ack), .busy(busy), .done(done), .err(err), .rdata(rdata),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // phase record: {cs, sk, do, di_to_drive}
    task automatic p_out(logic b);
        ph_q.push_back({1'b1, 1'b0, b, 1'b0});
        ph_q.push_back({1'b1, 1'b1, b, 1'b0});
        ph_q.push_back({1'b1, 1'b0, b, 1'b0});
    endtask
    task automatic p_word(logic [31:0] w, int n);
        for (int i = n - 1; i >= 0; i--) p_out(w[i]);
    endtask
    task automatic p_in(logic b);
        ph_q.push_back({1'b1, 1'b1, 1'b0, b});
        ph_q.push_back({1'b1, 1'b0, 1'b0, b});
    endtask
    task automatic p_desel();
        ph_q.push_back(4'b0000);
    endtask
    task automatic p_poll(logic v);
        ph_q.push_back({1'b1, 1'b0, 1'b0, v});
    endtask

    task automatic exp_read(logic [7:0] a, logic [15:0] d);
        p_word({1'b1, 2'b10, a}, 11);
        for (int i = 15; i >= 0; i--) p_in(d[i]);
        p_desel();
    endtask
    task automatic exp_polls(int n, logic ok);
        for (int i = 0; i < n; i++) p_poll(ok && (i == n - 1));
        p_desel();
    endtask

    task automatic run(string tag, logic [1:0] o, logic [7:0] a, logic [15:0] d,
                       logic exp_err, logic chk_rd, logic [15:0] exp_rd,
                       int noise_from, int noise_to);
        int n;
        n = ph_q.size();
        @(negedge clk);
        req = 1'b1; op = o; addr = a; wdata = d;
        @(posedge clk);
        for (int k = 0; k < n; k++) begin
            logic [3:0] e;
            e = ph_q[k];
            for (int c = 0; c < PH; c++) begin
                @(negedge clk);
                ee_di = e[0];
                if (k >= noise_from && k < noise_to) begin
                    req = 1'b1; op = ~o; addr = ~a;
                end else begin
                    req = 1'b0; op = o; addr = a;
                end
                chk(tag, {29'b0, ee_cs, ee_sk, ee_do}, {29'b0, e[3:1]}, "pins");
                chk("R2", busy, 1, "busy");
                chk((k >= noise_from && k < noise_to) ? "R10" : "R2", ack, (k == 0 && c == 0), "ack");
                chk("R9", done, 0, "done early");
            end
        end
        @(negedge clk);
        req = 1'b0; ee_di = 1'b0;
        chk("R9", done, 1, "done");
        chk("R9", busy, 0, "busy at done");
        chk(exp_err ? "R7" : "R9", err, exp_err, "err");
        if (chk_rd) chk("R4", rdata, exp_rd, "rdata");
        @(negedge clk);
        chk("R9", done, 0, "done pulse width");
        chk("R1", {ee_cs, ee_sk, ee_do}, 0, "pins idle");
        ph_q.delete();
    endtask

    task automatic exp_write(logic [7:0] a, logic [15:0] d, int n1, int n2);
        p_word({1'b1, 2'b00, 8'hFF}, 11); p_desel();
        p_word({1'b1, 2'b11, a}, 11);     p_desel();
        exp_polls(n1, 1'b1);
        p_word({1'b1, 2'b01, a, d}, 27);  p_desel();
        exp_polls(n2, 1'b1);
        p_word({1'b1, 2'b00, 8'h00}, 11); p_desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL R9 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {ack, busy, done, err, ee_cs, ee_sk, ee_do}, 0, "in reset");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", {ack, busy, done, err, ee_cs, ee_sk, ee_do}, 0, "after reset");

        // R4 read, mixed pattern
        exp_read(8'hA5, 16'hC35A);
        run("R4", 2'b00, 8'hA5, 16'h0000, 1'b0, 1'b1, 16'hC35A, -1, -1);
        // R4 read at address limits
        exp_read(8'hFF, 16'h0001);
        run("R4", 2'b00, 8'hFF, 16'h0000, 1'b0, 1'b1, 16'h0001, -1, -1);
        exp_read(8'h00, 16'hFFFF);
        run("R4", 2'b00, 8'h00, 16'h0000, 1'b0, 1'b1, 16'hFFFF, -1, -1);

        // R5 R6 write, quick ready then ready at limit; R10 noise while busy
        exp_write(8'h3C, 16'h1234, 2, PL);
        run("R5", 2'b01, 8'h3C, 16'h1234, 1'b0, 1'b0, 16'h0, 5, 60);
        // R6 ready on first poll
        exp_write(8'h81, 16'hBEEF, 1, 1);
        run("R6", 2'b01, 8'h81, 16'hBEEF, 1'b0, 1'b0, 16'h0, -1, -1);

        // R7 timeout on erase poll, request aborted
        p_word({1'b1, 2'b00, 8'hFF}, 11); p_desel();
        p_word({1'b1, 2'b11, 8'h55}, 11); p_desel();
        exp_polls(PL, 1'b0);
        run("R7", 2'b01, 8'h55, 16'hAAAA, 1'b1, 1'b0, 16'h0, -1, -1);

        // R9 err clears on next normal request; R4 rdata from it
        exp_read(8'h12, 16'h8000);
        run("R9", 2'b00, 8'h12, 16'h0000, 1'b0, 1'b1, 16'h8000, -1, -1);

        // R8 protect, both encodings; R10 noise
        p_word({1'b1, 2'b00, 8'h00}, 11); p_desel();
        run("R8", 2'b10, 8'h77, 16'h0000, 1'b0, 1'b1, 16'h8000, 2, 20);
        p_word({1'b1, 2'b00, 8'h00}, 11); p_desel();
        run("R8", 2'b11, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h8000, -1, -1);

        repeat (2) @(negedge clk);
        chk("R1", {ack, busy, done, ee_cs, ee_sk, ee_do}, 0, "idle end");
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule